// File: doc/BRIEF.md
# JTAG Programming-Mode Register Interface

This block is the target-side data path behind an IEEE 1149.1 TAP controller. The TAP state machine is outside the block. It appears here only as capture, shift and update strobes for the instruction and data paths, plus TDI and TDO, all timed by TCK. A 4-bit instruction register selects one data register. Five registers carry the standard scan chain and the programming protocol: bypass, device ID, core-reset, programming key and programming command. A page byte port covers the page load and page read instructions.

A host enters programming mode by writing a 16-bit key. The host then shifts 15-bit commands, and the erase-start and page-write-start commands launch an operation. The host polls for the end of the operation by re-shifting a command and reading bit 9 of the captured word. The flash array is replaced by a stub that holds the done flag low for a fixed number of TCK cycles. The stub is a two-state machine:
- `BZ_IDLE` (done = 1) moves to `BZ_RUN` when a start command is accepted.
- `BZ_RUN` restarts its count when another start command is accepted.
- `BZ_RUN` returns to `BZ_IDLE` when the count reaches zero.

Top module: `jtag_prog_port`

## Requirements
- R1: After trst_n is asserted low, core_hold and prog_active are 0 and the IDCODE instruction (0x1) is selected. A 32-bit data scan taken straight after reset therefore returns the ID word.
- R2: The instruction register is 4 bits wide, is shifted LSB first, and captures the value 4'b0001. A new instruction takes effect only on an instruction update.
- R3: The ID word is {VERSION[3:0], PART[15:0], 11'h01F, 1'b1}, with the version in bits 31:28, the part number in bits 27:12, the manufacturer code in bits 11:1 and a 1 in bit 0.
- R4: BYPASS (0xF), EXTEST (0x0), SAMPLE/PRELOAD (0x2) and every code without a register all select a 1-bit register that captures 0. TDO then repeats TDI one shift later.
- R5: The core-reset instruction (0xC) selects a 1-bit register. An update with 1 sets core_hold and an update with 0 clears it. A capture returns the current core_hold.
- R6: The key instruction (0x4) selects a 16-bit register that captures 0. An update sets prog_active only when the shifted value is KEY (default 0xA370). An update with any other value, including 0, clears prog_active.
- R7: The command instruction (0x5) selects a 15-bit register. On capture, bit 9 holds (done AND prog_active) and every other bit is 0. Commands updated while prog_active is 0 start nothing.
- R8: With prog_active set, an update of the command register whose bits 14:8 equal 0x31 (erase start) or 0x35 (page-write start) clears done at that edge. done sets again exactly BUSY_CYCLES TCK cycles later. Other command values leave done unchanged.
- R9: Page load (0x6) and page read (0x7) each shift 8 bits. Each load update stores the byte at the next buffer index, starting from 0 after the instruction is selected and wrapping after PAGE_BYTES. Each read capture returns bytes in the same order, starting from 0. Buffer bytes reset to 0xFF, and a load while prog_active is 0 stores nothing.
- R10: Data shifts LSB first. TDI enters at the MSB of the selected register. TDO is updated on the falling edge of TCK. The bits shifted beyond the register length repeat TDI delayed by the register length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; capture, shift and update act on its rising edge |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data in |
| capture_ir | input | 1 | Capture strobe for the instruction register |
| shift_ir | input | 1 | Shift enable for the instruction register |
| update_ir | input | 1 | Update strobe for the instruction register |
| capture_dr | input | 1 | Capture strobe for the selected data register |
| shift_dr | input | 1 | Shift enable for the selected data register |
| update_dr | input | 1 | Update strobe for the selected data register |
| tdo | output | 1 | Serial data out, changed on the falling edge of tck |
| core_hold | output | 1 | Holds the core in reset while 1 |
| prog_active | output | 1 | Programming mode is open |

## Verification
The bench builds the block with BUSY_CYCLES = 50 and PAGE_BYTES = 4, with its own version and part number. With a 50-cycle busy window, a rejected command followed by the key unlock can be shown to leave done high, because the unlock finishes inside the window. The same window lets several status polls read the busy flag before it clears, so the clear cycle can be bracketed from both sides. A 4-byte buffer lets five loads and five reads show the index wrap.

// File: rtl/jpr_pkg.sv
package jpr_pkg;

    localparam int IR_W = 4;
    localparam int DR_W = 32;

    // instruction codes (values are part of the host protocol)
    localparam logic [IR_W-1:0] OP_EXTEST = 4'h0;
    localparam logic [IR_W-1:0] OP_IDCODE = 4'h1;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'h2;
    localparam logic [IR_W-1:0] OP_KEY    = 4'h4;
    localparam logic [IR_W-1:0] OP_CMD    = 4'h5;
    localparam logic [IR_W-1:0] OP_LOAD   = 4'h6;
    localparam logic [IR_W-1:0] OP_READ   = 4'h7;
    localparam logic [IR_W-1:0] OP_HOLD   = 4'hC;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'hF;

    localparam logic [10:0] MFG_CODE     = 11'h01F;
    localparam logic [6:0]  CMD_ERASE_GO = 7'h31;
    localparam logic [6:0]  CMD_WRITE_GO = 7'h35;
    localparam int          DONE_BIT     = 9;

    typedef enum logic [2:0] {
        SEL_BYP,
        SEL_ID,
        SEL_RST,
        SEL_KEY,
        SEL_CMD,
        SEL_PAGE
    } dr_sel_e;

    typedef enum logic {
        BZ_IDLE,
        BZ_RUN
    } busy_state_e;

    function automatic dr_sel_e decode_sel(input logic [IR_W-1:0] op);
        case (op)
            OP_IDCODE:       return SEL_ID;
            OP_HOLD:         return SEL_RST;
            OP_KEY:          return SEL_KEY;
            OP_CMD:          return SEL_CMD;
            OP_LOAD, OP_READ: return SEL_PAGE;
            default:         return SEL_BYP;
        endcase
    endfunction

    function automatic logic [5:0] sel_len(input dr_sel_e sel);
        case (sel)
            SEL_ID:   return 6'd32;
            SEL_KEY:  return 6'd16;
            SEL_CMD:  return 6'd15;
            SEL_PAGE: return 6'd8;
            default:  return 6'd1;
        endcase
    endfunction

endpackage

// File: rtl/jpr_ir.sv
module jpr_ir
    import jpr_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            capture_ir,
    input  logic            shift_ir,
    input  logic            update_ir,
    output logic [IR_W-1:0] instr,
    output logic            ir_lsb
);

    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sr <= '0;
            instr <= OP_IDCODE;
        end else begin
            if (capture_ir) begin
                ir_sr <= IR_W'(2'b01);
            end else if (shift_ir) begin
                ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            end
            if (update_ir) begin
                instr <= ir_sr;
            end
        end
    end

    assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/jpr_busy.sv
module jpr_busy
    import jpr_pkg::*;
#(
    parameter int BUSY_CYCLES = 1000
) (
    input  logic tck,
    input  logic trst_n,
    input  logic start_op,
    output logic done
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    busy_state_e      state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            state <= BZ_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            BZ_IDLE: begin
                if (start_op) begin
                    state_nxt = BZ_RUN;
                    cnt_nxt   = CNT_LOAD;
                end
            end
            BZ_RUN: begin
                if (start_op) begin
                    cnt_nxt = CNT_LOAD;
                end else if (cnt == '0) begin
                    state_nxt = BZ_IDLE;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        done = (state == BZ_IDLE);
    end

endmodule

// File: rtl/jpr_dr.sv
module jpr_dr
    import jpr_pkg::*;
#(
    parameter logic [DR_W-1:0] ID_WORD    = 32'h1000_003F,
    parameter logic [15:0]     KEY        = 16'hA370,
    parameter int              PAGE_BYTES = 16
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            capture_dr,
    input  logic            shift_dr,
    input  logic            update_dr,
    input  logic [IR_W-1:0] instr,
    input  logic            flash_done,
    output logic            dr_lsb,
    output logic            core_hold,
    output logic            prog_active,
    output logic            start_op
);

    localparam int PTR_W = $clog2(PAGE_BYTES);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(PAGE_BYTES - 1);

    dr_sel_e          sel;
    logic [5:0]       cur_len;
    logic [DR_W-1:0]  dr_sr, shifted, cap_val;
    logic [7:0]       page_buf [PAGE_BYTES];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             cmd_go, load_ok;

    always_comb begin
        sel     = decode_sel(instr);
        cur_len = sel_len(sel);
    end

    always_comb begin
        shifted = dr_sr >> 1;
        shifted[cur_len - 6'd1] = tdi;
    end

    always_comb begin
        cap_val = '0;
        case (sel)
            SEL_ID:   cap_val = ID_WORD;
            SEL_RST:  cap_val[0] = core_hold;
            SEL_CMD:  cap_val[DONE_BIT] = flash_done & prog_active;
            SEL_PAGE: if (instr == OP_READ) cap_val[7:0] = page_buf[rd_ptr];
            default:  cap_val = '0;
        endcase
    end

    always_comb begin
        cmd_go   = (dr_sr[14:8] == CMD_ERASE_GO) || (dr_sr[14:8] == CMD_WRITE_GO);
        start_op = update_dr && (sel == SEL_CMD) && prog_active && cmd_go;
        load_ok  = update_dr && (instr == OP_LOAD) && prog_active;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            dr_sr       <= '0;
            core_hold   <= 1'b0;
            prog_active <= 1'b0;
        end else begin
            if (capture_dr) begin
                dr_sr <= cap_val;
            end else if (shift_dr) begin
                dr_sr <= shifted;
            end
            if (update_dr && sel == SEL_RST) begin
                core_hold <= dr_sr[0];
            end
            if (update_dr && sel == SEL_KEY) begin
                prog_active <= (dr_sr[15:0] == KEY);
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) begin
                page_buf[i] <= 8'hFF;
            end
        end else begin
            if (instr != OP_LOAD) begin
                wr_ptr <= '0;
            end else if (load_ok) begin
                page_buf[wr_ptr] <= dr_sr[7:0];
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (instr != OP_READ) begin
                rd_ptr <= '0;
            end else if (capture_dr) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
        end
    end

    assign dr_lsb = dr_sr[0];

endmodule

// File: rtl/jtag_prog_port.sv
module jtag_prog_port
    import jpr_pkg::*;
#(
    parameter logic [3:0]  VERSION     = 4'h1,
    parameter logic [15:0] PART        = 16'h5A3C,
    parameter logic [15:0] KEY         = 16'hA370,
    parameter int          BUSY_CYCLES = 1000,
    parameter int          PAGE_BYTES  = 16
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tdi,
    input  logic capture_ir,
    input  logic shift_ir,
    input  logic update_ir,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic update_dr,
    output logic tdo,
    output logic core_hold,
    output logic prog_active
);

    localparam logic [DR_W-1:0] ID_WORD = {VERSION, PART, MFG_CODE, 1'b1};

    logic [IR_W-1:0] instr;
    logic            ir_lsb, dr_lsb;
    logic            flash_done, start_op;

    jpr_ir u_ir (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .capture_ir (capture_ir),
        .shift_ir   (shift_ir),
        .update_ir  (update_ir),
        .instr      (instr),
        .ir_lsb     (ir_lsb)
    );

    jpr_dr #(
        .ID_WORD    (ID_WORD),
        .KEY        (KEY),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_dr (
        .tck         (tck),
        .trst_n      (trst_n),
        .tdi         (tdi),
        .capture_dr  (capture_dr),
        .shift_dr    (shift_dr),
        .update_dr   (update_dr),
        .instr       (instr),
        .flash_done  (flash_done),
        .dr_lsb      (dr_lsb),
        .core_hold   (core_hold),
        .prog_active (prog_active),
        .start_op    (start_op)
    );

    jpr_busy #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_busy (
        .tck      (tck),
        .trst_n   (trst_n),
        .start_op (start_op),
        .done     (flash_done)
    );

    // output stage on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo <= 1'b0;
        end else begin
            tdo <= shift_ir ? ir_lsb : dr_lsb;
        end
    end

endmodule

// File: rtl/jtag_prog_port_chk.sv
module jtag_prog_port_chk #(
    parameter int BUSY_CYCLES = 1000
) (
    input logic       tck,
    input logic       trst_n,
    input logic       update_ir,
    input logic       update_dr,
    input logic [3:0] instr,
    input logic       core_hold,
    input logic       prog_active,
    input logic       flash_done,
    input logic       start_op
);

    logic [31:0] since_start;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            since_start <= '0;
        end else if (start_op) begin
            since_start <= '0;
        end else if (since_start != 32'hFFFF_FFFF) begin
            since_start <= since_start + 1'b1;
        end
    end

    // R2
    instr_commit_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(instr) |-> $past(update_ir));

    // R5
    hold_change_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !$stable(core_hold) |-> $past(update_dr));

    // R6
    prog_open_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(prog_active) |-> ($past(update_dr) && $past(instr) == 4'h4));

    // R8
    busy_clear_chk: assert property (@(posedge tck) disable iff (!trst_n)
        start_op |=> !flash_done);

    // R8
    busy_length_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(flash_done) |-> (since_start == 32'(BUSY_CYCLES)));

endmodule

bind jtag_prog_port jtag_prog_port_chk #(
    .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
    .tck         (tck),
    .trst_n      (trst_n),
    .update_ir   (update_ir),
    .update_dr   (update_dr),
    .instr       (instr),
    .core_hold   (core_hold),
    .prog_active (prog_active),
    .flash_done  (flash_done),
    .start_op    (start_op)
);

// File: tb/jtag_prog_port_test.sv
`timescale 1ns/1ps
module jtag_prog_port_test;

    localparam logic [3:0]  VER = 4'h3;
    localparam logic [15:0] PRT = 16'h5A3C;
    localparam int          BC  = 50;
    localparam int          PB  = 4;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tdi = 1'b0;
    logic capture_ir = 1'b0, shift_ir = 1'b0, update_ir = 1'b0;
    logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic tdo, core_hold, prog_active;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cap_cyc = 0;
    int upd_cyc = 0;

    string       exp_tag [$];
    logic [63:0] exp_val [$];

    jtag_prog_port #(
        .VERSION     (VER),
        .PART        (PRT),
        .BUSY_CYCLES (BC),
        .PAGE_BYTES  (PB)
    ) uut (
        .tck         (tck),
        .trst_n      (trst_n),
        .tdi         (tdi),
        .capture_ir  (capture_ir),
        .shift_ir    (shift_ir),
        .update_ir   (update_ir),
        .capture_dr  (capture_dr),
        .shift_dr    (shift_dr),
        .update_dr   (update_dr),
        .tdo         (tdo),
        .core_hold   (core_hold),
        .prog_active (prog_active)
    );

    always #4 tck = ~tck;
    always @(posedge tck) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_val(input string tag, input logic [63:0] v);
        exp_tag.push_back(tag);
        exp_val.push_back(v);
    endtask

    // monitor side of the scoreboard
    task automatic observe(input logic [63:0] act);
        if (exp_tag.size() == 0) begin
            check("scoreboard-empty", act, 64'hX);
        end else begin
            check(exp_tag.pop_front(), act, exp_val.pop_front());
        end
    endtask

    task automatic ir_scan(input logic [3:0] code, output logic [3:0] cap);
        capture_ir = 1'b1;
        @(posedge tck); #1;
        capture_ir = 1'b0;
        for (int i = 0; i < 4; i++) begin
            shift_ir = 1'b1;
            tdi = code[i];
            @(negedge tck); #1;
            cap[i] = tdo;
            @(posedge tck); #1;
        end
        shift_ir = 1'b0;
        update_ir = 1'b1;
        @(posedge tck); #1;
        update_ir = 1'b0;
    endtask

    task automatic ir(input logic [3:0] code);
        logic [3:0] dummy;
        ir_scan(code, dummy);
    endtask

    task automatic dr_scan(input int len, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        capture_dr = 1'b1;
        @(posedge tck); #1;
        cap_cyc = cyc;
        capture_dr = 1'b0;
        for (int i = 0; i < len; i++) begin
            shift_dr = 1'b1;
            tdi = din[i];
            @(negedge tck); #1;
            dout[i] = tdo;
            @(posedge tck); #1;
        end
        shift_dr = 1'b0;
        update_dr = 1'b1;
        @(posedge tck); #1;
        upd_cyc = cyc;
        update_dr = 1'b0;
    endtask

    task automatic dr_obs(input int len, input logic [63:0] din);
        logic [63:0] d;
        dr_scan(len, din, d);
        observe(d);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0]  irc;
        logic [63:0] d;
        logic [31:0] idw;
        int          start_k;
        bit          seen;
        idw = {VER, PRT, 11'h01F, 1'b1};

        repeat (3) @(posedge tck);
        #1 trst_n = 1'b1;
        @(posedge tck); #1;

        // R1: reset state
        check("R1 core_hold", core_hold, 0);
        check("R1 prog_active", prog_active, 0);
        // R1, R3: IDCODE selected out of reset, ID layout
        expect_val("R3 id word", {32'h0, idw});
        dr_obs(32, 64'h0);

        // R10: 40 bits through the 32-bit ID register, LSB first, TDI delayed by 32
        expect_val("R10 id passthrough", {24'h0, 8'hA5, idw});
        dr_obs(40, 64'h0000_00A5_0000_0000 >> 32);

        // R2: instruction capture pattern
        ir_scan(4'hF, irc);
        check("R2 ir capture", irc, 4'b0001);

        // R4: bypass-like instructions
        expect_val("R4 bypass", 64'b0110);
        dr_obs(4, 64'b1011);
        ir(4'h0);
        expect_val("R4 extest", 64'b0110);
        dr_obs(4, 64'b1011);
        ir(4'h2);
        expect_val("R4 sample", 64'b1010);
        dr_obs(4, 64'b1101);
        ir(4'h9);
        expect_val("R4 unassigned", 64'b0010);
        dr_obs(4, 64'b0001);

        // R5: core reset register
        ir(4'hC);
        expect_val("R5 capture0", 64'h0);
        dr_obs(1, 64'h1);
        check("R5 hold set", core_hold, 1);
        expect_val("R5 capture1", 64'h1);
        dr_obs(1, 64'h0);
        check("R5 hold clear", core_hold, 0);

        // R9: load while locked is dropped
        ir(4'h6);
        dr_scan(8, 64'h12, d);

        // R6: wrong key keeps locked
        ir(4'h4);
        expect_val("R6 key capture", 64'h0);
        dr_obs(16, 64'h1234);
        check("R6 wrong key", prog_active, 0);

        // R7: start command while locked is ignored, status reads 0
        ir(4'h5);
        expect_val("R7 locked status", 64'h0);
        dr_obs(15, 64'h3500);

        // R6: correct key opens
        ir(4'h4);
        dr_scan(16, 64'hA370, d);
        check("R6 key opens", prog_active, 1);

        // R7: done reads 1, no operation was started by the locked command
        ir(4'h5);
        expect_val("R7 status idle", 64'h0200);
        dr_obs(15, 64'h2380);

        // R8: page-write start, poll until done
        expect_val("R8 status before start", 64'h0200);
        dr_obs(15, 64'h3500);
        start_k = upd_cyc;
        seen = 1'b0;
        for (int p = 0; p < 20 && !seen; p++) begin
            dr_scan(15, 64'h3700, d);
            if (d == 64'h0200) begin
                seen = 1'b1;
                check("R8 done not early", (cap_cyc - start_k >= BC + 1), 1);
            end else begin
                check("R8 busy reads 0", d, 64'h0);
                check("R8 busy not late", (cap_cyc - start_k <= BC), 1);
            end
        end
        check("R8 done seen", seen, 1);

        // R9: loads ignored while locked left 0xFF
        ir(4'h7);
        expect_val("R9 erased byte", 64'hFF);
        dr_obs(8, 64'h0);

        // R9: five loads into four bytes wrap
        ir(4'h6);
        dr_scan(8, 64'hA1, d);
        dr_scan(8, 64'hB2, d);
        dr_scan(8, 64'hC3, d);
        dr_scan(8, 64'hD4, d);
        dr_scan(8, 64'hE5, d);
        ir(4'h7);
        expect_val("R9 read0", 64'hE5);
        expect_val("R9 read1", 64'hB2);
        expect_val("R9 read2", 64'hC3);
        expect_val("R9 read3", 64'hD4);
        expect_val("R9 read wrap", 64'hE5);
        for (int r = 0; r < 5; r++) begin
            dr_obs(8, 64'h0);
        end

        // R6: writing zero closes programming mode
        ir(4'h4);
        dr_scan(16, 64'h0, d);
        check("R6 zero closes", prog_active, 0);
        // R7: status masked once closed
        ir(4'h5);
        expect_val("R7 status closed", 64'h0);
        dr_obs(15, 64'h2300);

        check("scoreboard drained", exp_tag.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule